// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog with a small register port. Each register accepts a write only when the written word carries that register's own key. A write with the wrong key is dropped without any effect. A reference-tick enable, one pulse per slow-clock cycle, drives a prescaler. Each time the prescaler wraps, a down-counter decrements. Software loads the counter with a programmed length, then sets the enable bit. It must keep restarting the count before the count runs out.

When the count runs out, the block does one of three things, depending on the control bits. It can raise a sticky interrupt. It can pulse a reset output for a fixed number of reference ticks. In two-stage mode, it first raises the interrupt, reloads the counter, and issues the reset only if a second expiry follows. A separate keyed register starts the reset pulse at once, whatever the counter holds.

Top module: `keyguard_wdt`

## Requirements
- R1: A write to the control register (byte offset 0x00) is taken only when wdata[31:24] is 0x22. Four bits are stored: bit 0 is enable, bit 2 is reset-output enable, bit 3 is interrupt select and bit 6 is two-stage mode. A read at 0x00 returns those four bits in the same positions, with all other bits zero.
- R2: A write to the length register (offset 0x04) is taken only when wdata[4:0] is 0x08. The length is wdata[LEN_W+4:5], and any higher bits are ignored. A read at 0x04 returns the length in bits [LEN_W+4:5], with all other bits zero.
- R3: A write whose key does not match leaves the stored control bits and length unchanged.
- R4: After reset, the control register reads 0, the length is all ones, the counter and prescaler are zero, and both outputs are low.
- R5: While enabled, the counter decrements once every PRESC_DIV reference ticks. Expiry happens on the tick that takes the count to zero, which is length×PRESC_DIV ticks after a restart. On expiry the counter reloads from the length.
- R6: Writing exactly 0x1971 to offset 0x08 reloads the counter from the length, clears the prescaler, the interrupt and the two-stage flag. Any other value written there does nothing.
- R7: While the enable bit is clear, the prescaler and counter hold their values. Setting the bit again resumes the count from where it stopped.
- R8: With interrupt select and two-stage mode both clear, an expiry starts a reset pulse only if reset-output enable is set. The reset output then stays high until RST_TICKS further reference ticks have passed.
- R9: With interrupt select set and two-stage mode clear, an expiry raises the interrupt and no reset. The interrupt stays high until a valid restart.
- R10: With two-stage mode set, the first expiry raises the interrupt and reloads the counter. The next expiry without a restart is handled as in R8.
- R11: Writing exactly 0x1209 to offset 0x14 starts the reset pulse on the next clock edge, regardless of the enable and reset-output bits. Any other value written there is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data, including the key |
| rdata | output | 32 | Read data for `addr` (combinational) |
| wdt_irq | output | 1 | Expiry interrupt, held until restart |
| wdt_rst | output | 1 | Reset request pulse |

## Verification
The bench builds the block with PRESC_DIV set to 4 and keeps LEN_W at 11 and RST_TICKS at 4. With these values, an expiry from a length of 3 takes only 12 reference ticks. This puts the exact expiry tick, both stages of two-stage mode, a freeze-and-resume sequence and the end of the reset pulse within a short run. Keeping LEN_W at its default means the reset-state length readback checks the full 11-bit field, 0xFFE0.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_LEN     = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RESTART = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_SWRST   = 5'h14;

    localparam logic [7:0]  CTRL_KEY    = 8'h22;
    localparam logic [4:0]  LEN_KEY     = 5'h08;
    localparam logic [31:0] RESTART_KEY = 32'h0000_1971;
    localparam logic [31:0] SWRST_KEY   = 32'h0000_1209;

    typedef struct packed {
        logic dual;
        logic irq_sel;
        logic ext_rst;
        logic en;
    } mode_t;

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output mode_t             mode,
    output logic [LEN_W-1:0]  len,
    output logic              restart_stb,
    output logic              swrst_stb,
    output logic [31:0]       rdata
);

    typedef struct packed {
        mode_t            mode;
        logic [LEN_W-1:0] len;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        restart_stb = 1'b0;
        swrst_stb   = 1'b0;
        if (wr_en) begin
            unique case (addr)
                OFS_CTRL: begin
                    if (wdata[31:24] == CTRL_KEY) begin
                        r_d.mode.en      = wdata[0];
                        r_d.mode.ext_rst = wdata[2];
                        r_d.mode.irq_sel = wdata[3];
                        r_d.mode.dual    = wdata[6];
                    end
                end
                OFS_LEN: begin
                    if (wdata[4:0] == LEN_KEY)
                        r_d.len = wdata[LEN_W+4:5];
                end
                OFS_RESTART: restart_stb = (wdata == RESTART_KEY);
                OFS_SWRST:   swrst_stb   = (wdata == SWRST_KEY);
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_CTRL) begin
            rdata[0] = r_q.mode.en;
            rdata[2] = r_q.mode.ext_rst;
            rdata[3] = r_q.mode.irq_sel;
            rdata[6] = r_q.mode.dual;
        end else if (addr == OFS_LEN) begin
            rdata[LEN_W+4:5] = r_q.len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode <= '0;
            r_q.len  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode = r_q.mode;
    assign len  = r_q.len;

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int PRESC_DIV = 512,
    parameter int LEN_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  mode_t            mode,
    input  logic [LEN_W-1:0] len,
    input  logic             restart_stb,
    output logic             irq,
    output logic             rst_req,
    output logic [LEN_W-1:0] cnt_o
);

    localparam int PRESC_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
    localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(PRESC_DIV - 1);

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [LEN_W-1:0]   cnt;
        logic               irq;
        logic               stage;
    } core_t;

    core_t c_q, c_d;

    always_comb begin
        c_d     = c_q;
        rst_req = 1'b0;
        if (restart_stb) begin
            c_d.presc = '0;
            c_d.cnt   = len;
            c_d.irq   = 1'b0;
            c_d.stage = 1'b0;
        end else if (mode.en && ref_tick) begin
            if (c_q.presc == PRESC_LAST) begin
                c_d.presc = '0;
                if (c_q.cnt <= LEN_W'(1)) begin
                    c_d.cnt = len;
                    if (!c_q.stage && (mode.irq_sel || mode.dual)) begin
                        c_d.irq   = 1'b1;
                        c_d.stage = mode.dual;
                    end else begin
                        c_d.stage = 1'b0;
                        rst_req   = mode.ext_rst;
                    end
                end else begin
                    c_d.cnt = c_q.cnt - LEN_W'(1);
                end
            end else begin
                c_d.presc = c_q.presc + PRESC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign irq   = c_q.irq;
    assign cnt_o = c_q.cnt;

endmodule

// File: rtl/kwdt_rstgen.sv
module kwdt_rstgen #(
    parameter int RST_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic trig,
    output logic rst_o
);

    localparam int RSTC_W = $clog2(RST_TICKS + 1);

    logic [RSTC_W-1:0] left_q, left_d;

    always_comb begin
        left_d = left_q;
        if (trig)
            left_d = RSTC_W'(RST_TICKS);
        else if (ref_tick && left_q != '0)
            left_d = left_q - RSTC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign rst_o = (left_q != '0);

endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
    import kwdt_pkg::*;
#(
    parameter int PRESC_DIV = 512,
    parameter int LEN_W     = 11,
    parameter int RST_TICKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        wr_en,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        wdt_irq,
    output logic        wdt_rst
);

    mode_t            mode_s;
    logic [LEN_W-1:0] len_s;
    logic [LEN_W-1:0] cnt_s;
    logic             restart_s;
    logic             swrst_s;
    logic             exp_rst_s;

    kwdt_regs #(.LEN_W(LEN_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .mode       (mode_s),
        .len        (len_s),
        .restart_stb(restart_s),
        .swrst_stb  (swrst_s),
        .rdata      (rdata)
    );

    kwdt_core #(.PRESC_DIV(PRESC_DIV), .LEN_W(LEN_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .mode       (mode_s),
        .len        (len_s),
        .restart_stb(restart_s),
        .irq        (wdt_irq),
        .rst_req    (exp_rst_s),
        .cnt_o      (cnt_s)
    );

    kwdt_rstgen #(.RST_TICKS(RST_TICKS)) u_rstgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_tick(ref_tick),
        .trig    (swrst_s | exp_rst_s),
        .rst_o   (wdt_rst)
    );

endmodule

// File: rtl/keyguard_wdt_chk.sv
module keyguard_wdt_chk
    import kwdt_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_tick,
    input logic             wr_en,
    input logic [4:0]       addr,
    input logic [31:0]      wdata,
    input logic             wdt_irq,
    input logic             wdt_rst,
    input mode_t            mode_bits,
    input logic [LEN_W-1:0] len_val,
    input logic [LEN_W-1:0] cnt_val
);

    logic restart_wr;
    assign restart_wr = wr_en && addr == 5'h08 && wdata == 32'h1971;

    // R1
    ctrl_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'h00 && wdata[31:24] != 8'h22) |=> $stable(mode_bits));

    // R3
    len_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'h04 && wdata[4:0] != 5'h08) |=> $stable(len_val));

    // R6
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_wr |=> (!wdt_irq && cnt_val == $past(len_val)));

    // R7
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_bits.en && !restart_wr) |=> $stable(cnt_val));

    // R8
    rst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst) |-> $past(ref_tick));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_irq && !restart_wr) |=> wdt_irq);

    // R11
    swrst_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'h14 && wdata == 32'h1209) |=> wdt_rst);

endmodule

bind keyguard_wdt keyguard_wdt_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .wdt_irq  (wdt_irq),
    .wdt_rst  (wdt_rst),
    .mode_bits(mode_s),
    .len_val  (len_s),
    .cnt_val  (cnt_s)
);

// File: tb/keyguard_wdt_bench.sv
`timescale 1ns/1ps
module keyguard_wdt_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wdt_irq, wdt_rst;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    keyguard_wdt #(.PRESC_DIV(4), .LEN_W(11), .RST_TICKS(4)) u_keyguard_wdt (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
    );

    typedef struct packed {
        logic [4:0]  a;
        logic [31:0] d;
        logic [31:0] ctrl_exp;
        logic [31:0] len_exp;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{5'h00, 32'h2200_004C, 32'h4C, 32'hFFE0},
        '{5'h00, 32'h2300_000D, 32'h4C, 32'hFFE0},
        '{5'h00, 32'h2200_00FF, 32'h4D, 32'hFFE0},
        '{5'h00, 32'h2200_0000, 32'h00, 32'hFFE0},
        '{5'h04, 32'h0000_0068, 32'h00, 32'h0060},
        '{5'h04, 32'h0000_0069, 32'h00, 32'h0060},
        '{5'h04, 32'hFFFF_0048, 32'h00, 32'h0040},
        '{5'h04, 32'h0000_0007, 32'h00, 32'h0040},
        '{5'h00, 32'h0000_0005, 32'h00, 32'h0040},
        '{5'h04, 32'h0000_0068, 32'h00, 32'h0060}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ref_tick = 1'b1;
            @(negedge clk) ref_tick = 1'b0;
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset state
        rd(5'h00, v); chk("R4 ctrl", v, 32'h0);
        rd(5'h04, v); chk("R4 len", v, 32'hFFE0);
        chk("R4 irq", {31'b0, wdt_irq}, 32'h0);
        chk("R4 rst", {31'b0, wdt_rst}, 32'h0);

        // R1 R2 R3 key filtering table
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i].a, VEC[i].d);
            rd(5'h00, v); chk("R1/R3 ctrl readback", v, VEC[i].ctrl_exp);
            rd(5'h04, v); chk("R2/R3 len readback", v, VEC[i].len_exp);
        end

        // R5 R8 reset mode expiry and pulse width (len=3)
        wr(5'h08, 32'h1971);
        wr(5'h00, 32'h2200_0005);
        ticks(11); chk("R5 before expiry", {31'b0, wdt_rst}, 0);
        ticks(1);  chk("R5 expiry tick", {31'b0, wdt_rst}, 1);
        ticks(3);  chk("R8 pulse held", {31'b0, wdt_rst}, 1);
        ticks(1);  chk("R8 pulse ends", {31'b0, wdt_rst}, 0);
        wr(5'h00, 32'h2200_0004);

        // R8 no pulse without reset-output enable
        wr(5'h08, 32'h1971);
        wr(5'h00, 32'h2200_0001);
        ticks(12); chk("R8 no ext rst", {30'b0, wdt_irq, wdt_rst}, 0);
        wr(5'h00, 32'h2200_0000);

        // R9 interrupt mode
        wr(5'h08, 32'h1971);
        wr(5'h00, 32'h2200_000D);
        ticks(12); chk("R9 irq first", {30'b0, wdt_irq, wdt_rst}, 2);
        ticks(12); chk("R9 irq held", {30'b0, wdt_irq, wdt_rst}, 2);
        wr(5'h08, 32'h1971);
        chk("R6 restart clears irq", {31'b0, wdt_irq}, 0);
        wr(5'h00, 32'h2200_0000);

        // R10 two-stage
        wr(5'h08, 32'h1971);
        wr(5'h00, 32'h2200_0045);
        ticks(12); chk("R10 stage one", {30'b0, wdt_irq, wdt_rst}, 2);
        ticks(11); chk("R10 before stage two", {31'b0, wdt_rst}, 0);
        ticks(1);  chk("R10 stage two", {31'b0, wdt_rst}, 1);
        wr(5'h00, 32'h2200_0000);
        wr(5'h08, 32'h1971);
        ticks(4);

        // R7 freeze and resume
        wr(5'h08, 32'h1971);
        wr(5'h00, 32'h2200_0005);
        ticks(5);
        wr(5'h00, 32'h2200_0004);
        ticks(100); chk("R7 frozen", {31'b0, wdt_rst}, 0);
        wr(5'h00, 32'h2200_0005);
        ticks(6);  chk("R7 resumed early", {31'b0, wdt_rst}, 0);
        ticks(1);  chk("R7 resumed expiry", {31'b0, wdt_rst}, 1);
        wr(5'h00, 32'h2200_0004);
        ticks(4);

        // R6 wrong restart value ignored
        wr(5'h08, 32'h1971);
        wr(5'h00, 32'h2200_0005);
        ticks(8);
        wr(5'h08, 32'h1970);
        ticks(3);  chk("R6 bad restart early", {31'b0, wdt_rst}, 0);
        ticks(1);  chk("R6 bad restart ignored", {31'b0, wdt_rst}, 1);
        wr(5'h00, 32'h2200_0004);
        ticks(4);

        // R6 good restart mid-prescaler reloads and clears prescaler
        wr(5'h08, 32'h1971);
        wr(5'h00, 32'h2200_0005);
        ticks(9);
        wr(5'h08, 32'h1971);
        ticks(11); chk("R6 restart extends", {31'b0, wdt_rst}, 0);
        ticks(1);  chk("R6 full period", {31'b0, wdt_rst}, 1);
        wr(5'h00, 32'h2200_0004);
        ticks(4);

        // R11 software reset
        wr(5'h00, 32'h2200_0000);
        wr(5'h14, 32'h1208);
        chk("R11 wrong value", {31'b0, wdt_rst}, 0);
        wr(5'h14, 32'h1209);
        chk("R11 immediate", {31'b0, wdt_rst}, 1);
        ticks(3);  chk("R11 held", {31'b0, wdt_rst}, 1);
        ticks(1);  chk("R11 ends", {31'b0, wdt_rst}, 0);

        // R5 minimum length
        wr(5'h04, 32'h0000_0028);
        wr(5'h08, 32'h1971);
        wr(5'h00, 32'h2200_0005);
        ticks(3);  chk("R5 len1 early", {31'b0, wdt_rst}, 0);
        ticks(1);  chk("R5 len1 expiry", {31'b0, wdt_rst}, 1);

        summary();
        $finish;
    end

endmodule